// File: doc/BRIEF.md
# Packed Allocation Tag Access Unit

The unit reads and writes 4-bit allocation tags kept in a byte-wide tag memory. Every tag byte carries the tags of two neighbouring 16-byte data granules, so one tag byte covers 32 bytes of data. A single command presents an opcode, a data-side byte address, a tag and a 64-bit data word. The unit turns that command into one or more accesses on a synchronous memory port with a one-cycle read latency, and then pulses `done_o`.

The unit provides six operations: single-granule tag load and store, a two-granule tag store, a 64-bit bulk tag load and a bulk tag store over an aligned block, and a fill that writes one tag across a whole aligned block. Single-granule updates use read-modify-write so that the neighbouring tag in the same byte keeps its value. A granule store or double store whose address is not aligned to 16 bytes is refused with a fault. While a command is in progress the unit reports not-ready and ignores its command inputs. The first cycle in which it is ready again is also the cycle in which it pulses `done_o`, so a new command can be accepted in that cycle.

Top module: `tag_pack_unit`

## Requirements
- R1: While `rst_ni` is low, `ready_o`=1 and `done_o`, `fault_o` and `mem_en_o` are 0. `rdata_o` is 0 until the first load finishes.
- R2: The tag byte address is `cmd_addr_i >> 5`. Address bit 4 picks the nibble: 0 selects bits 3:0 and 1 selects bits 7:4.
- R3: Opcode 0 (single load) returns `cmd_data_i` with bits 59:56 replaced by the selected nibble. It writes nothing to memory.
- R4: Opcode 1 (single store) at an aligned address writes `cmd_tag_i` into the selected nibble. The other nibble of that byte and every other byte are unchanged.
- R5: For opcode 1 or 2 with `cmd_addr_i[3:0]` nonzero, the unit pulses `fault_o` together with `done_o` in the cycle after acceptance. It makes no memory access.
- R6: Opcode 2 (double store) at an aligned address with bit 4 = 1 writes the tag into bits 7:4 of byte b and bits 3:0 of byte b+1. Every other nibble is unchanged.
- R7: Opcode 2 at an aligned address with bit 4 = 0 writes byte b as {tag, tag} with a single write.
- R8: Opcode 3 (bulk load) sets the base to `(cmd_addr_i >> 5)` rounded down to a multiple of 8. `rdata_o[8i+7:8i]` = memory[base+i] for i = 0..7 (little-endian).
- R9: Opcode 4 (bulk store) uses the same base as R8 and writes memory[base+i] = `cmd_data_i[8i+7:8i]` for i = 0..7.
- R10: Opcode 5 (fill) writes tag × 0x11 into N = 2^(FILL_SEL+2)/32 consecutive bytes, starting at `(cmd_addr_i >> 5)` rounded down to a multiple of N. The default N is 4.
- R11: The unit makes at most one memory access per cycle and only while `ready_o` is 0. `done_o` is a one-cycle pulse, and `ready_o` is high in that cycle. Measured from the accept edge, `done_o` rises after 3 cycles for a single load or store, 9 for a bulk store, 10 for a bulk load and N+1 for a fill. Commands presented while `ready_o` is 0 are ignored.
- R12: Opcodes 6 and 7 are ignored: the unit stays ready, does not pulse `done_o` and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present; taken when ready_o is 1 |
| cmd_op_i | input | 3 | Opcode (0..5 defined) |
| cmd_addr_i | input | ADDR_W | Data-side byte address |
| cmd_tag_i | input | 4 | Tag for store, double store and fill |
| cmd_data_i | input | DATA_W | Destination word (single load) or tag word (bulk store) |
| ready_o | output | 1 | Idle and able to take a command |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Alignment fault, valid with done_o |
| rdata_o | output | DATA_W | Load result |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | ADDR_W-5 | Tag byte address |
| mem_wdata_o | output | 8 | Tag byte write data |
| mem_rdata_i | input | 8 | Tag byte read data, one cycle after the read |

## Verification
Two events can fall in the same cycle: the completion of one command and the acceptance of the next. The bench provokes this by presenting each next command at the falling edge where it sees `done_o`. Often the earlier command is a read-modify-write to the same or a neighbouring tag byte, so a late final write or a dropped acceptance would corrupt the result. A second overlap is the alignment fault: its completion falls one cycle after acceptance, and the following command is again presented in that cycle. After every command the bench compares the whole tag memory against a reference model and also checks the load results.

// File: rtl/tpu_pkg.sv
package tpu_pkg;
  localparam int GRAN_LOG   = 4;  // 16-byte granule
  localparam int PAIR_LOG   = 5;  // two granules per tag byte
  localparam int TAG_W      = 4;

  typedef enum logic [2:0] {
    OP_LD1  = 3'd0,
    OP_ST1  = 3'd1,
    OP_ST2  = 3'd2,
    OP_LDB  = 3'd3,
    OP_STB  = 3'd4,
    OP_FILL = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_MOD,
    S_WSEQ,
    S_RSEQ
  } state_e;
endpackage

// File: rtl/tpu_addr_map.sv
module tpu_addr_map
  import tpu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BULK_N = 8,
  parameter int FILL_N = 4,
  localparam int TAG_AW = ADDR_W - PAIR_LOG
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [TAG_AW-1:0] byte_idx_o,
  output logic              hi_o,
  output logic              aligned_o,
  output logic [TAG_AW-1:0] bulk_base_o,
  output logic [TAG_AW-1:0] fill_base_o
);
  localparam logic [TAG_AW-1:0] BULK_MASK = ~TAG_AW'(BULK_N - 1);
  localparam logic [TAG_AW-1:0] FILL_MASK = ~TAG_AW'(FILL_N - 1);

  assign byte_idx_o  = addr_i[ADDR_W-1:PAIR_LOG];
  assign hi_o        = addr_i[GRAN_LOG];
  assign aligned_o   = (addr_i[GRAN_LOG-1:0] == '0);
  assign bulk_base_o = byte_idx_o & BULK_MASK;
  assign fill_base_o = byte_idx_o & FILL_MASK;
endmodule

// File: rtl/tpu_nib_merge.sv
module tpu_nib_merge
  import tpu_pkg::*;
(
  input  logic [7:0]       byte_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             hi_i,
  output logic [7:0]       byte_o,
  output logic [TAG_W-1:0] nib_o
);
  assign nib_o  = hi_i ? byte_i[7:4] : byte_i[3:0];
  assign byte_o = hi_i ? {tag_i, byte_i[3:0]} : {byte_i[7:4], tag_i};
endmodule

// File: rtl/tag_pack_unit.sv
module tag_pack_unit
  import tpu_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 64,
  parameter int FILL_SEL = 5,
  parameter int TAG_LSB  = 56
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [3:0]        cmd_tag_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              fault_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-6:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  localparam int TAG_AW = ADDR_W - PAIR_LOG;
  localparam int BULK_N = DATA_W / 8;
  localparam int FILL_N = (1 << (FILL_SEL + 2)) >> PAIR_LOG;
  localparam int MAX_N  = (FILL_N > BULK_N) ? FILL_N : BULK_N;
  localparam int CW     = $clog2(MAX_N + 1);

  state_e            state_q;
  op_e               op_q;
  logic [TAG_AW-1:0] base_q;
  logic              hi_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] data_q, rdata_q, ld_word;
  logic [CW-1:0]     cnt_q, last_q;
  logic              done_q, fault_q;

  logic [TAG_AW-1:0] byte_idx, bulk_base, fill_base;
  logic              addr_hi, addr_al;
  logic [7:0]        merged;
  logic [TAG_W-1:0]  nib;

  tpu_addr_map #(.ADDR_W(ADDR_W), .BULK_N(BULK_N), .FILL_N(FILL_N)) u_map (
    .addr_i      (cmd_addr_i),
    .byte_idx_o  (byte_idx),
    .hi_o        (addr_hi),
    .aligned_o   (addr_al),
    .bulk_base_o (bulk_base),
    .fill_base_o (fill_base)
  );

  // second byte of a straddling double store flips to the low nibble
  tpu_nib_merge u_merge (
    .byte_i (mem_rdata_i),
    .tag_i  (tag_q),
    .hi_i   (hi_q ^ cnt_q[0]),
    .byte_o (merged),
    .nib_o  (nib)
  );

  always_comb begin
    ld_word = data_q;
    ld_word[TAG_LSB +: TAG_W] = nib;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      op_q    <= OP_LD1;
      base_q  <= '0;
      hi_q    <= 1'b0;
      tag_q   <= '0;
      data_q  <= '0;
      rdata_q <= '0;
      cnt_q   <= '0;
      last_q  <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (cmd_valid_i && cmd_op_i <= 3'(OP_FILL)) begin
          op_q   <= op_e'(cmd_op_i);
          tag_q  <= cmd_tag_i;
          data_q <= cmd_data_i;
          hi_q   <= addr_hi;
          cnt_q  <= '0;
          last_q <= '0;
          base_q <= byte_idx;
          case (op_e'(cmd_op_i))
            OP_LD1: state_q <= S_RD;
            OP_ST1, OP_ST2: begin
              if (!addr_al) begin
                done_q  <= 1'b1;
                fault_q <= 1'b1;
              end else if (cmd_op_i == 3'(OP_ST2) && addr_hi) begin
                last_q  <= CW'(1);
                state_q <= S_RD;
              end else if (cmd_op_i == 3'(OP_ST2)) begin
                state_q <= S_WSEQ;
              end else begin
                state_q <= S_RD;
              end
            end
            OP_LDB: begin
              base_q  <= bulk_base;
              state_q <= S_RSEQ;
            end
            OP_STB: begin
              base_q  <= bulk_base;
              last_q  <= CW'(BULK_N - 1);
              state_q <= S_WSEQ;
            end
            default: begin
              base_q  <= fill_base;
              last_q  <= CW'(FILL_N - 1);
              state_q <= S_WSEQ;
            end
          endcase
        end
        S_RD: state_q <= S_MOD;
        S_MOD: begin
          if (op_q == OP_LD1) begin
            rdata_q <= ld_word;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else if (cnt_q == last_q) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            cnt_q   <= cnt_q + 1'b1;
            state_q <= S_RD;
          end
        end
        S_WSEQ: begin
          data_q <= data_q >> 8;
          if (cnt_q == last_q) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_RSEQ: begin
          if (cnt_q != '0) rdata_q <= {mem_rdata_i, rdata_q[DATA_W-1:8]};
          if (cnt_q == CW'(BULK_N)) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_wdata_o = {tag_q, tag_q};
    unique case (state_q)
      S_RD:   mem_en_o = 1'b1;
      S_MOD: begin
        mem_en_o    = (op_q != OP_LD1);
        mem_we_o    = (op_q != OP_LD1);
        mem_wdata_o = merged;
      end
      S_WSEQ: begin
        mem_en_o = 1'b1;
        mem_we_o = 1'b1;
        if (op_q == OP_STB) mem_wdata_o = data_q[7:0];
      end
      S_RSEQ: mem_en_o = (cnt_q < CW'(BULK_N));
      default: ;
    endcase
  end

  assign mem_addr_o = base_q + TAG_AW'(cnt_q);
  assign ready_o    = (state_q == S_IDLE);
  assign done_o     = done_q;
  assign fault_o    = fault_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/tpu_checker.sv
module tpu_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [2:0]        cmd_op_i,
  input logic [ADDR_W-1:0] cmd_addr_i,
  input logic              ready_o,
  input logic              done_o,
  input logic              fault_o,
  input logic              mem_en_o,
  input logic              mem_we_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_reset_quiet_r1: assert (ready_o && !done_o && !fault_o && !mem_en_o);
    end
  end

  p_fault_with_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o);

  p_misaligned_fault_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && cmd_valid_i && (cmd_op_i == 3'd1 || cmd_op_i == 3'd2) && cmd_addr_i[3:0] != 4'd0)
    |=> (fault_o && done_o && !mem_en_o));

  p_load_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && cmd_valid_i && cmd_op_i == 3'd0) |=> !mem_we_o);

  p_idle_no_access_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !mem_en_o);

  p_done_when_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ready_o);

  p_write_needs_enable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_en_o);

  p_undefined_ignored_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && cmd_valid_i && cmd_op_i > 3'd5) |=> (ready_o && !done_o));
endmodule

bind tag_pack_unit tpu_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .cmd_addr_i  (cmd_addr_i),
  .ready_o     (ready_o),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .mem_en_o    (mem_en_o),
  .mem_we_o    (mem_we_o)
);

// File: tb/tb_tag_pack_unit.sv
`timescale 1ns/1ps
module tb_tag_pack_unit;
  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 64;
  localparam int FILL_SEL = 5;
  localparam int FN       = (1 << (FILL_SEL + 2)) / 32;
  localparam int DEPTH    = 1 << (ADDR_W - 5);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [3:0] cmd_tag = '0;
  logic [DATA_W-1:0] cmd_data = '0;
  logic ready_o, done_o, fault_o, mem_en_o, mem_we_o;
  logic [DATA_W-1:0] rdata_o;
  logic [ADDR_W-6:0] mem_addr_o;
  logic [7:0] mem_wdata_o, mem_rdata;

  logic [7:0] mem [DEPTH];
  logic [7:0] ref_mem [DEPTH];
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (mem_en_o) begin
      if (mem_we_o) mem[mem_addr_o] <= mem_wdata_o;
      else mem_rdata <= mem[mem_addr_o];
    end
  end

  tag_pack_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FILL_SEL(FILL_SEL), .TAG_LSB(56)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_addr_i(cmd_addr), .cmd_tag_i(cmd_tag), .cmd_data_i(cmd_data),
    .ready_o(ready_o), .done_o(done_o), .fault_o(fault_o), .rdata_o(rdata_o),
    .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata)
  );

  // {op[3], addr[16], tag[4], data[64], fault[1]}
  localparam logic [87:0] VEC [0:13] = '{
    {3'd0, 16'h0040, 4'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
    {3'd0, 16'h0050, 4'h0, 64'h0123_4567_89AB_CDEF, 1'b0},
    {3'd1, 16'h0120, 4'hA, 64'h0, 1'b0},
    {3'd1, 16'h0130, 4'h5, 64'h0, 1'b0},
    {3'd1, 16'h0134, 4'hE, 64'h0, 1'b1},
    {3'd2, 16'h0210, 4'hC, 64'h0, 1'b0},
    {3'd2, 16'h0300, 4'h7, 64'h0, 1'b0},
    {3'd2, 16'h0308, 4'h9, 64'h0, 1'b1},
    {3'd3, 16'h0A57, 4'h0, 64'h0, 1'b0},
    {3'd4, 16'h1234, 4'h0, 64'h0123_4567_89AB_CDEF, 1'b0},
    {3'd3, 16'h1200, 4'h0, 64'h0, 1'b0},
    {3'd5, 16'h0777, 4'h3, 64'h0, 1'b0},
    {3'd0, 16'h0710, 4'h0, 64'h0, 1'b0},
    {3'd2, 16'h0130, 4'h6, 64'h0, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] op, input logic hi, input logic flt);
    if (flt) return "R5";
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return hi ? "R6" : "R7";
      3'd3: return "R8";
      3'd4: return "R9";
      default: return "R10";
    endcase
  endfunction

  // reference model built from the requirements
  task automatic ref_apply(input logic [2:0] op, input logic [15:0] a, input logic [3:0] t,
                           input logic [63:0] d, output logic flt, output logic [63:0] rd);
    logic [10:0] bi, base;
    bi  = a[15:5];
    flt = 1'b0;
    rd  = d;
    case (op)
      3'd0: rd[59:56] = a[4] ? ref_mem[bi][7:4] : ref_mem[bi][3:0];
      3'd1: if (a[3:0] != 0) flt = 1'b1;
            else if (a[4]) ref_mem[bi][7:4] = t; else ref_mem[bi][3:0] = t;
      3'd2: if (a[3:0] != 0) flt = 1'b1;
            else if (a[4]) begin ref_mem[bi][7:4] = t; ref_mem[bi + 11'd1][3:0] = t; end
            else ref_mem[bi] = {t, t};
      3'd3: begin base = bi & ~11'd7;
              for (int i = 0; i < 8; i++) rd[8*i +: 8] = ref_mem[base + 11'(i)]; end
      3'd4: begin base = bi & ~11'd7;
              for (int i = 0; i < 8; i++) ref_mem[base + 11'(i)] = d[8*i +: 8]; end
      default: begin base = bi & ~11'(FN - 1);
              for (int i = 0; i < FN; i++) ref_mem[base + 11'(i)] = {t, t}; end
    endcase
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < DEPTH; i++)
      if (mem[i] !== ref_mem[i]) begin bad++; if (first < 0) first = i; end
    if (first < 0) check(req, 64'd0, 64'd0);
    else check(req, {32'(first), 24'd0, mem[first]}, {32'(first), 24'd0, ref_mem[first]});
  endtask

  // starts and ends at a falling edge; returns cycles from accept edge to done
  task automatic run_cmd(input logic [2:0] op, input logic [15:0] a, input logic [3:0] t,
                         input logic [63:0] d, output int lat);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_tag = t; cmd_data = d;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!done_o && lat < 100);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    logic ef;
    logic [63:0] er;
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = 8'(i * 37 + 5);
      ref_mem[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {59'd0, ready_o, done_o, fault_o, mem_en_o, mem_we_o}, 64'b10000);
    check("R1 rdata reset", rdata_o, 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R12: undefined opcode has no effect
    cmd_valid = 1'b1; cmd_op = 3'd6; cmd_addr = 16'h0020; cmd_tag = 4'hF;
    @(posedge clk); #1; cmd_valid = 1'b0;
    begin
      int bad = 0;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        if (done_o || mem_en_o || !ready_o) bad++;
      end
      check("R12 undefined opcode activity", 64'(bad), 64'd0);
    end
    cmp_mem("R12 memory unchanged");

    // vector table, each command presented in the done cycle of the previous one
    for (int i = 0; i < 14; i++) begin
      logic [87:0] v;
      string rq;
      v = VEC[i];
      ref_apply(v[87:85], v[84:69], v[68:65], v[64:1], ef, er);
      rq = req_of(v[87:85], v[73], v[0]);
      run_cmd(v[87:85], v[84:69], v[68:65], v[64:1], lat);
      check({rq, " fault flag"}, {63'd0, fault_o}, {63'd0, v[0]});
      check({rq, " fault model"}, {63'd0, ef}, {63'd0, v[0]});
      if (v[87:85] == 3'd0 || v[87:85] == 3'd3) check({rq, " R2 load data"}, rdata_o, er);
      cmp_mem({rq, " R2 memory"});
    end

    // R11 latencies
    ref_apply(3'd1, 16'h0400, 4'h2, 64'd0, ef, er);
    run_cmd(3'd1, 16'h0400, 4'h2, 64'd0, lat);
    check("R11 single store latency", 64'(lat), 64'd3);
    ref_apply(3'd0, 16'h0400, 4'h0, 64'd0, ef, er);
    run_cmd(3'd0, 16'h0400, 4'h0, 64'd0, lat);
    check("R11 single load latency", 64'(lat), 64'd3);
    check("R3 load after store", rdata_o, er);
    ref_apply(3'd5, 16'h0C00, 4'hB, 64'd0, ef, er);
    run_cmd(3'd5, 16'h0C00, 4'hB, 64'd0, lat);
    check("R11 fill latency", 64'(lat), 64'(FN + 1));
    ref_apply(3'd3, 16'h0C00, 4'h0, 64'd0, ef, er);
    run_cmd(3'd3, 16'h0C00, 4'h0, 64'd0, lat);
    check("R11 bulk load latency", 64'(lat), 64'd10);
    check("R10 fill readback", rdata_o, er);

    // R11: command while busy is ignored, bulk store latency
    ref_apply(3'd4, 16'h2000, 4'h0, 64'hDEAD_BEEF_CAFE_F00D, ef, er);
    cmd_valid = 1'b1; cmd_op = 3'd4; cmd_addr = 16'h2000; cmd_data = 64'hDEAD_BEEF_CAFE_F00D;
    @(posedge clk); #1;
    cmd_op = 3'd1; cmd_addr = 16'h4000; cmd_tag = 4'hF;
    @(negedge clk);
    check("R11 busy not ready", {63'd0, ready_o}, 64'd0);
    lat = 1;
    @(negedge clk); lat++;
    cmd_valid = 1'b0;
    while (!done_o && lat < 100) begin @(negedge clk); lat++; end
    check("R11 bulk store latency", 64'(lat), 64'd9);
    repeat (2) @(negedge clk);
    check("R11 done single pulse", {63'd0, done_o}, 64'd0);
    cmp_mem("R9 R11 busy command dropped");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule